// File: doc/BRIEF.md
# Oscillator warm-up counter

This block holds the processor back while an oscillator settles. It runs after reset is released, and again whenever a start trigger arrives, for example on wake from the stop mode or after a change of operating mode. The oscillators are not modelled. Each clock is an enable input that is high for one cycle of the block clock per oscillator period. A source select picks the fast or the slow enable. A predivider of three binary stages then passes one tick in 1, 2, 4 or 8 to a 14-bit up-counter.

The upper eight bits of the count are compared with a programmable value. On a match, the enable-CPU output goes high, a single-cycle interrupt pulse is issued, and counting stops until the next start. A compare value of zero means the longest wait, 255 steps of the upper byte. A separate clear input zeroes the count and the predivider without starting or stopping the wait.

Top module: `warmup_ctr`

## Requirements
- R1: While reset is held, `cpu_en` and `wu_irq` are low. Releasing reset starts a warm-up from a zero count.
- R2: `src_sel`=0 counts `hf_tick` and `src_sel`=1 counts `lf_tick`. The enable that is not selected has no effect on the count.
- R3: `div_sel` values 0, 1, 2 and 3 need 1, 2, 4 and 8 selected ticks per counter increment.
- R4: Let N be 64 × target × divisor ticks. If the selected enable is high on every cycle, the count reaches N at the Nth clock edge after the start edge. `cpu_en` then goes high at edge N+1, and `wu_irq` is high for exactly that one cycle. The target is compared against count bits [13:6].
- R5: After completion, counting stops. `cpu_en` stays high and no further `wu_irq` occurs until the next start.
- R6: A `cmp_val` of 0 acts as a target of 255.
- R7: `start` clears the count and the predivider, drives `cpu_en` low on the next edge and begins a new warm-up. It has priority over every other input.
- R8: `cnt_clr` clears the count and the predivider and leaves the running or finished state unchanged. It overrides a match in the same cycle. When the block is finished it has no visible effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset; its release starts a warm-up |
| hf_tick | input | 1 | High-frequency oscillator enable |
| lf_tick | input | 1 | Low-frequency oscillator enable |
| src_sel | input | 1 | 0 selects `hf_tick`, 1 selects `lf_tick` |
| div_sel | input | 2 | Predivision: 0 → /1, 1 → /2, 2 → /4, 3 → /8 |
| cmp_val | input | 8 | Target for count bits [13:6]; 0 means 255 |
| cnt_clr | input | 1 | Clears the count and the predivider without starting |
| start | input | 1 | Clears the count and begins a new warm-up |
| cpu_en | output | 1 | High once the warm-up has completed |
| wu_irq | output | 1 | One-cycle pulse on completion |

## Verification
The hardest case to reach is a clear that lands partway through a running wait. Its effect shows only as a shifted completion edge several dozen cycles later. The stimulus counts clock edges from the start edge, pulses `cnt_clr` on a chosen edge, and predicts the completion cycle exactly from that edge. The longest wait, with a zero compare value, is run to its end. The ignored-source case is driven with only the unselected enable active and watched over a window far longer than a full wait.

// File: rtl/warmup_ctr.sv
module warmup_ctr #(
  parameter int CNT_W = 14,
  parameter int CMP_W = 8,
  parameter int DIV_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       hf_tick,
  input  logic                       lf_tick,
  input  logic                       src_sel,
  input  logic [$clog2(DIV_W+1)-1:0] div_sel,
  input  logic [CMP_W-1:0]           cmp_val,
  input  logic                       cnt_clr,
  input  logic                       start,
  output logic                       cpu_en,
  output logic                       wu_irq
);
  logic [DIV_W-1:0] pre;
  logic [DIV_W-1:0] mask;
  logic [CNT_W-1:0] cnt;
  logic [CMP_W-1:0] target;
  logic             busy;
  logic             src, step, hit;

  assign src    = src_sel ? lf_tick : hf_tick;
  assign mask   = DIV_W'(({{DIV_W{1'b0}}, 1'b1} << div_sel) - 1'b1);
  assign step   = busy & src & ((pre & mask) == mask);
  assign target = (cmp_val == '0) ? '1 : cmp_val;
  assign hit    = busy & (cnt[CNT_W-1 -: CMP_W] == target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre    <= '0;
      cnt    <= '0;
      busy   <= 1'b1;
      cpu_en <= 1'b0;
      wu_irq <= 1'b0;
    end else begin
      wu_irq <= 1'b0;
      if (start) begin
        pre    <= '0;
        cnt    <= '0;
        busy   <= 1'b1;
        cpu_en <= 1'b0;
      end else if (cnt_clr) begin
        pre <= '0;
        cnt <= '0;
      end else if (hit) begin
        busy   <= 1'b0;
        cpu_en <= 1'b1;
        wu_irq <= 1'b1;
      end else if (busy) begin
        if (src)  pre <= pre + 1'b1;
        if (step) cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/warmup_ctr_chk.sv
module warmup_ctr_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic cnt_clr,
  input logic cpu_en,
  input logic wu_irq
);
  a_r4_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    wu_irq |=> !wu_irq);
  a_r4_irq_with_en: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_en) |-> wu_irq);
  a_r4_irq_means_en: assert property (@(posedge clk) disable iff (!rst_n)
    wu_irq |-> cpu_en);
  a_r5_en_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_en && !start) |=> cpu_en);
  a_r7_start_drops: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!cpu_en && !wu_irq));
  a_r8_clr_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> !wu_irq);
  a_r8_clr_keeps_en: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_clr && !start) |=> (cpu_en == $past(cpu_en)));
endmodule

bind warmup_ctr warmup_ctr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cnt_clr(cnt_clr),
  .cpu_en(cpu_en), .wu_irq(wu_irq)
);

// File: tb/warmup_ctr_tb.sv
module warmup_ctr_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hf_tick = 1'b1, lf_tick = 1'b0, src_sel = 1'b0;
  logic [1:0] div_sel = 2'd0;
  logic [7:0] cmp_val = 8'd1;
  logic cnt_clr = 1'b0, start = 1'b0;
  logic cpu_en, wu_irq;
  int checks = 0, fails = 0, cyc = 0;

  always #2 clk = ~clk;

  warmup_ctr u_dut (
    .clk(clk), .rst_n(rst_n), .hf_tick(hf_tick), .lf_tick(lf_tick),
    .src_sel(src_sel), .div_sel(div_sel), .cmp_val(cmp_val),
    .cnt_clr(cnt_clr), .start(start), .cpu_en(cpu_en), .wu_irq(wu_irq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic kick();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input int lim, inout int n);
    while (!cpu_en && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic run_and_check(input int exp, input string tag);
    int n = 0;
    kick();
    check(!cpu_en, {tag, " R7 cpu_en low after start"}, int'(cpu_en), 0);
    wait_done(exp + 20, n);
    check(n == exp, {tag, " completion cycle"}, n, exp);
    check(wu_irq, {tag, " R4 irq at completion"}, int'(wu_irq), 1);
    @(negedge clk);
    check(!wu_irq && cpu_en, {tag, " R4 irq one cycle"}, int'(wu_irq), 0);
  endtask

  task automatic t_reset();
    int n = 0;
    repeat (3) @(negedge clk);
    check(!cpu_en && !wu_irq, "R1 outputs low in reset", int'(cpu_en | wu_irq), 0);
    rst_n = 1'b1;
    wait_done(100, n);
    check(n == 65, "R1 R4 warm-up after reset release", n, 65);
    check(wu_irq, "R4 irq with cpu_en", int'(wu_irq), 1);
    @(negedge clk);
    check(!wu_irq, "R4 irq single pulse", int'(wu_irq), 0);
  endtask

  task automatic t_div();
    for (int d = 0; d < 4; d++) begin
      div_sel = 2'(d);
      run_and_check(64 * (1 << d) + 1, "R3 divide");
    end
    div_sel = 2'd0;
  endtask

  task automatic t_cmp();
    cmp_val = 8'd3;
    run_and_check(193, "R4 target 3");
    cmp_val = 8'd0;
    run_and_check(16321, "R6 zero target");
    cmp_val = 8'd1;
  endtask

  task automatic t_src();
    int irqs = 0;
    src_sel = 1'b1; hf_tick = 1'b0; lf_tick = 1'b1;
    run_and_check(65, "R2 low-frequency source");
    src_sel = 1'b0;
    kick();
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (wu_irq) irqs++;
    end
    check(!cpu_en && irqs == 0, "R2 unselected enable ignored", int'(cpu_en) + irqs, 0);
    hf_tick = 1'b1; lf_tick = 1'b0;
    run_and_check(65, "R2 high-frequency source");
  endtask

  task automatic t_hold();
    int irqs = 0, lows = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (wu_irq) irqs++;
      if (!cpu_en) lows++;
    end
    check(irqs == 0, "R5 no irq after completion", irqs, 0);
    check(lows == 0, "R5 cpu_en stays high", lows, 0);
  endtask

  task automatic t_clr();
    int n = 0, irqs = 0;
    kick();
    repeat (30) @(negedge clk);
    cnt_clr = 1'b1;
    @(negedge clk);
    cnt_clr = 1'b0;
    n = 31;
    wait_done(200, n);
    check(n == 96, "R8 clear mid-run delays completion", n, 96);
    @(negedge clk);
    cnt_clr = 1'b1;
    @(negedge clk);
    cnt_clr = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (wu_irq) irqs++;
    end
    check(cpu_en && irqs == 0, "R8 clear when finished has no effect", irqs, 0);
  endtask

  task automatic t_restart();
    int n = 0;
    kick();
    repeat (40) @(negedge clk);
    kick();
    check(!cpu_en, "R7 restart keeps cpu_en low", int'(cpu_en), 0);
    wait_done(200, n);
    check(n == 65, "R7 restart counts from zero", n, 65);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_div();
    t_cmp();
    t_src();
    t_hold();
    t_clr();
    t_restart();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule